// File: doc/BRIEF.md
# Operand-Two Barrel Shifter

This combinational unit forms the second source operand of a data-processing instruction. It looks only at the low twelve instruction bits and at one select bit that picks the operand form. The register file is read elsewhere: the values of the shifted register (Rm) and of the amount register (Rs) come in as inputs. The unit returns the finished operand and a shifter carry, which the ALU may use as its carry flag on logical operations.

There are two forms. In the immediate form, an 8-bit constant is rotated right by an even amount. In the register form, Rm is shifted by one of four shift kinds. The shift amount comes either from a 5-bit instruction field or from the low byte of Rs. Any zero amount passes the value through unchanged and carries the incoming C flag out. Amounts at or beyond the word width saturate in a defined way.

Top module: `op2_shifter`

## Requirements
- R1: When `imm_sel` is 1, `op2` equals `instr_op[7:0]`, zero-extended and rotated right by twice the value of `instr_op[11:8]`. `rm_val` and `rs_val` have no effect.
- R2: In the immediate form, `c_out` equals `c_in` when `instr_op[11:8]` is 0. Otherwise `c_out` equals bit 31 of `op2`.
- R3: When `imm_sel` is 0, the shifted value is `rm_val`. The shift kind is `instr_op[6:5]`: 00 = logical left, 01 = logical right, 10 = arithmetic right, 11 = rotate right. When `instr_op[4]` is 0, the amount is `instr_op[11:7]`.
- R4: When `instr_op[4]` is 1, the amount is `rs_val[7:0]`. Bits above bit 7 of `rs_val` have no effect.
- R5: A register-form amount of 0 gives `op2 = rm_val` and `c_out = c_in`, for every shift kind.
- R6: Logical left by n. For 1..31, `c_out` is `rm_val[32-n]`. For n = 32, `op2` is 0 and `c_out` is `rm_val[0]`. Above 32, both are 0.
- R7: Logical right by n. For 1..31, `c_out` is `rm_val[n-1]`. For n = 32, `op2` is 0 and `c_out` is `rm_val[31]`. Above 32, both are 0.
- R8: Arithmetic right by n fills the top with `rm_val[31]`. For 1..31, `c_out` is `rm_val[n-1]`. For n of 32 or more, every bit of `op2` and `c_out` equal `rm_val[31]`.
- R9: Rotate right by n rotates by n mod 32. A nonzero n gives `c_out` equal to bit 31 of `op2`. A nonzero multiple of 32 leaves `rm_val` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_op | input | 12 | Low twelve instruction bits |
| imm_sel | input | 1 | 1 selects the rotated-immediate form |
| rm_val | input | WIDTH | Value of the register to shift |
| rs_val | input | WIDTH | Value of the register holding the shift amount |
| c_in | input | 1 | Incoming carry flag |
| op2 | output | WIDTH | Second operand |
| c_out | output | 1 | Shifter carry-out |

## Verification
The bench builds the unit with the default WIDTH of 32. At that width the encodings are small enough to enumerate. Every one of the 4096 immediate encodings is applied with both carry values. Every shift kind is swept over all 32 field amounts and over register amounts 0 through 70 and 255, with six data patterns. This reaches each saturation edge at 31, 32 and 33, and the rotate wrap at 64. Further Rs values differ only above bit 7, which shows that those bits are ignored.

// File: rtl/op2_shifter.sv
module op2_shifter #(
  parameter int WIDTH = 32
) (
  input  logic [11:0]      instr_op,
  input  logic             imm_sel,
  input  logic [WIDTH-1:0] rm_val,
  input  logic [WIDTH-1:0] rs_val,
  input  logic             c_in,
  output logic [WIDTH-1:0] op2,
  output logic             c_out
);
  localparam int SHW = $clog2(WIDTH);

  function automatic logic [WIDTH-1:0] rotr(input logic [WIDTH-1:0] v, input logic [SHW-1:0] r);
    logic [2*WIDTH-1:0] d;
    d = {v, v} >> r;
    return d[WIDTH-1:0];
  endfunction

  logic [SHW-1:0]   imm_rot;
  logic [WIDTH-1:0] imm_val;
  logic [7:0]       amt;
  logic [WIDTH:0]   lsl_w, lsr_w, asr_w;
  logic [WIDTH-1:0] ror_v;

  assign imm_rot = SHW'({instr_op[11:8], 1'b0});
  assign imm_val = rotr(WIDTH'(instr_op[7:0]), imm_rot);

  assign amt   = instr_op[4] ? rs_val[7:0] : {3'b000, instr_op[11:7]};
  assign lsl_w = {1'b0, rm_val} << amt;
  assign lsr_w = {rm_val, 1'b0} >> amt;
  assign asr_w = $signed({rm_val, 1'b0}) >>> amt;
  assign ror_v = rotr(rm_val, amt[SHW-1:0]);

  always_comb begin
    op2   = rm_val;
    c_out = c_in;
    if (imm_sel) begin
      op2   = imm_val;
      c_out = (instr_op[11:8] == 4'd0) ? c_in : imm_val[WIDTH-1];
    end else if (amt != 8'd0) begin
      case (instr_op[6:5])
        2'b00: {c_out, op2} = lsl_w;
        2'b01: {op2, c_out} = lsr_w;
        2'b10: {op2, c_out} = asr_w;
        default: begin
          op2   = ror_v;
          c_out = ror_v[WIDTH-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/op2_shifter_chk.sv
module op2_shifter_chk #(
  parameter int WIDTH = 32
) (
  input logic [11:0]      instr_op,
  input logic             imm_sel,
  input logic [WIDTH-1:0] rm_val,
  input logic [WIDTH-1:0] rs_val,
  input logic             c_in,
  input logic [WIDTH-1:0] op2,
  input logic             c_out
);
  logic [8:0] n;
  assign n = instr_op[4] ? {1'b0, rs_val[7:0]} : {4'd0, instr_op[11:7]};

  always_comb begin
    if (!$isunknown({instr_op, imm_sel, rm_val, rs_val, c_in, op2, c_out})) begin
      if (imm_sel)
        assert_imm_bits_kept_R1: assert ($countones(op2) == $countones(instr_op[7:0]));
      if (imm_sel && instr_op[11:8] == 4'd0)
        assert_imm_norot_carry_R2: assert (c_out == c_in && op2 == WIDTH'(instr_op[7:0]));
      if (!imm_sel && n == 9'd0)
        assert_zero_amount_R5: assert (op2 == rm_val && c_out == c_in);
      if (!imm_sel && instr_op[6:5] == 2'b01 && n > 9'(WIDTH))
        assert_lsr_flush_R7: assert (op2 == '0 && !c_out);
      if (!imm_sel && instr_op[6:5] == 2'b10 && n >= 9'(WIDTH))
        assert_asr_signfill_R8: assert (op2 == {WIDTH{rm_val[WIDTH-1]}} && c_out == rm_val[WIDTH-1]);
      if (!imm_sel && instr_op[6:5] == 2'b11)
        assert_ror_bits_kept_R9: assert ($countones(op2) == $countones(rm_val));
    end
  end
endmodule

bind op2_shifter op2_shifter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_op2_shifter.sv
module tb_op2_shifter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [11:0] instr_op;
  logic        imm_sel;
  logic [31:0] rm_val, rs_val;
  logic        c_in;
  logic [31:0] op2;
  logic        c_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  op2_shifter dut (.*);

  // Bitwise reference: one single-bit step per loop pass, returns {carry, value}.
  function automatic logic [32:0] model(input logic [11:0] f, input logic sel,
                                        input logic [31:0] rm, input logic [31:0] rs, input logic c);
    logic [31:0] v;
    logic cy;
    int n;
    cy = c;
    if (sel) begin
      v = {24'd0, f[7:0]};
      for (int i = 0; i < 2 * f[11:8]; i++) v = {v[0], v[31:1]};
      if (f[11:8] != 0) cy = v[31];
      return {cy, v};
    end
    v = rm;
    n = f[4] ? int'(rs[7:0]) : int'(f[11:7]);
    if (n == 0) return {cy, v};
    case (f[6:5])
      2'b00: for (int i = 0; i < n && i < 40; i++) begin cy = v[31]; v = {v[30:0], 1'b0}; end
      2'b01: for (int i = 0; i < n && i < 40; i++) begin cy = v[0]; v = {1'b0, v[31:1]}; end
      2'b10: for (int i = 0; i < n && i < 40; i++) begin cy = v[0]; v = {v[31], v[31:1]}; end
      default: begin
        for (int i = 0; i < n % 32; i++) v = {v[0], v[31:1]};
        cy = v[31];
      end
    endcase
    return {cy, v};
  endfunction

  task automatic apply(input string tag, input logic [11:0] f, input logic sel,
                       input logic [31:0] rm, input logic [31:0] rs, input logic c);
    logic [32:0] exp;
    @(posedge clk);
    instr_op = f; imm_sel = sel; rm_val = rm; rs_val = rs; c_in = c;
    exp = model(f, sel, rm, rs, c);
    @(negedge clk);
    n_run++;
    if ({c_out, op2} !== exp) begin
      n_fail++;
      $display("FAIL %s: f=%h sel=%b rm=%h rs=%h c=%b got op2=%h c=%b exp op2=%h c=%b",
               tag, f, sel, rm, rs, c, op2, c_out, exp[31:0], exp[32]);
    end
  endtask

  function automatic string kind_tag(input logic [1:0] k);
    case (k)
      2'b00: return "R6";
      2'b01: return "R7";
      2'b10: return "R8";
      default: return "R9";
    endcase
  endfunction

  logic [31:0] pats [6] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96,
                            32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678};

  initial begin
    apply("R5", 12'h000, 1'b0, 32'h0, 32'h0, 1'b0);
    // immediate form, junk on register inputs
    for (int f = 0; f < 4096; f++) begin
      apply("R1", 12'(f), 1'b1, 32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b0);
      apply("R2", 12'(f), 1'b1, 32'h1357_9BDF, 32'hFFFF_FFFF, 1'b1);
    end
    // register form, amount from instruction field
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 6; p++)
          for (int c = 0; c < 2; c++)
            apply(a == 0 ? "R5" : "R3", {5'(a), 2'(k), 1'b0, 4'h3}, 1'b0, pats[p], 32'hFFFF_FF00, 1'(c));
    // register form, amount from Rs low byte
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 72; a++)
        for (int p = 0; p < 6; p++)
          for (int c = 0; c < 2; c++) begin
            int amt = (a == 71) ? 255 : a;
            apply(amt == 0 ? "R5" : kind_tag(2'(k)), {4'h5, 1'b0, 2'(k), 1'b1, 4'h2},
                  1'b0, pats[p], 32'(amt), 1'(c));
          end
    // upper Rs bits must be ignored
    for (int k = 0; k < 4; k++)
      for (int u = 0; u < 8; u++) begin
        apply("R4", {4'h1, 1'b0, 2'(k), 1'b1, 4'h0}, 1'b0, 32'hC0DE_1234, {24'(u * 32'h0012_3457), 8'd5}, 1'b0);
        apply("R4", {4'h1, 1'b0, 2'(k), 1'b1, 4'h0}, 1'b0, 32'hC0DE_1234, {24'(u + 1), 8'd0}, 1'b1);
      end
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 190000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule